// File: doc/BRIEF.md
# Sidetone Filter Coefficient Store

This block is the register front end of an audio sidetone filter. A host on a simple 32-bit register bus sets the sidetone on/off state, a power-saving idle request and two signed 16-bit channel gains, all of which drive output pins. The block also keeps a 128-entry table of signed 16-bit FIR coefficients for a separate filter datapath.

The host does not address the table entry by entry. It raises a load-enable bit and then writes every coefficient to one data register. An internal pointer steps through the table on each write. Once the last entry is stored, a read-only completion flag rises and a status bit is latched. The filter datapath reads the table through its own index port, and the entry appears one clock after the index.

Top module: `st_coef_ctrl`

## Requirements
- R1: Reading offset 0x00 returns the constant 32'h0001_0200. Writes to that offset have no effect.
- R2: Bit 0 of offset 0x10 is a read/write idle request, and it drives `idle_req`. The other bits read as zero.
- R3: Offset 0x24 holds the channel-0 gain in bits 15:0 and the channel-1 gain in bits 31:16. The register reads back as written and drives `gain_ch0` and `gain_ch1`.
- R4: Offset 0x2C is the control register. Bit 0 is the sidetone enable and drives `st_on`. Bit 1 is the load enable. Bit 2 is the read-only load-complete flag, and writes to it are ignored.
- R5: While the load enable is set, each write to offset 0x28 stores bits 15:0 of the write data into the next table entry, starting at index 0. Bits 31:16 are dropped. Reads of 0x28 return zero.
- R6: The load-complete flag rises on the 128th stored write and not before. Further data writes are then ignored until the load enable is cleared.
- R7: While the load enable is low, data writes are ignored. Clearing the load enable clears the flag and returns the pointer to index 0, so the next load restarts at entry 0.
- R8: `tap_val` equals the table entry at `tap_idx` one clock after the index is presented.
- R9: Bit 0 of offset 0x18 is set when a load completes and is cleared by writing 1 to it. Bit 0 of offset 0x1C is a read/write enable.
- R10: Reset sets every register, the pointer and every table entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| tap_idx | input | 7 | Coefficient index requested by the filter |
| tap_val | output | 16 | Coefficient at the index of the previous cycle |
| st_on | output | 1 | Sidetone enable |
| idle_req | output | 1 | Auto-idle request |
| gain_ch0 | output | 16 | Channel-0 gain |
| gain_ch1 | output | 16 | Channel-1 gain |

## Verification
The assertions assume that every access lasts exactly one cycle with `bus_en` high, and that the host raises the load enable only with a write to the control register. The properties that compare against the previous cycle's bus data also rely on no two accesses overlapping. The stimulus drives each access for a single cycle from the falling edge and returns `bus_en` low between accesses. It also changes the load enable only through the control register, including a clear in the middle of a load.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int COEF_W = 16;

    localparam logic [BUS_AW-1:0] OFS_REV   = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_CFG   = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_ISTAT = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_IEN   = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_GAIN  = 8'h24;
    localparam logic [BUS_AW-1:0] OFS_COEF  = 8'h28;
    localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h2C;

    localparam logic [BUS_DW-1:0] REV_VALUE = 32'h0001_0200;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_REV, SEL_CFG, SEL_ISTAT, SEL_IEN, SEL_GAIN, SEL_COEF, SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic [COEF_W-1:0] ch1;
        logic [COEF_W-1:0] ch0;
    } gain_t;

    typedef struct packed {
        logic load_en;
        logic st_on;
    } ctrl_t;

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] a);
        case (a)
            OFS_REV:   return SEL_REV;
            OFS_CFG:   return SEL_CFG;
            OFS_ISTAT: return SEL_ISTAT;
            OFS_IEN:   return SEL_IEN;
            OFS_GAIN:  return SEL_GAIN;
            OFS_COEF:  return SEL_COEF;
            OFS_CTRL:  return SEL_CTRL;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/st_regbank.sv
module st_regbank
    import st_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              done_i,
    input  logic              done_evt_i,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              coef_wr_o,
    output ctrl_t             ctrl_o,
    output gain_t             gain_o,
    output logic              idle_o
);
    reg_sel_e sel;
    logic     wr;
    logic     cfg_q, istat_q, ien_q;
    ctrl_t    ctrl_q;
    gain_t    gain_q;

    assign sel = decode_ofs(bus_addr);
    assign wr  = bus_en && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= 1'b0;
            istat_q <= 1'b0;
            ien_q   <= 1'b0;
            ctrl_q  <= '0;
            gain_q  <= '0;
        end else begin
            if (wr && sel == SEL_CFG)  cfg_q  <= bus_wdata[0];
            if (wr && sel == SEL_IEN)  ien_q  <= bus_wdata[0];
            if (wr && sel == SEL_GAIN) gain_q <= gain_t'(bus_wdata);
            if (wr && sel == SEL_CTRL) begin
                ctrl_q.st_on   <= bus_wdata[0];
                ctrl_q.load_en <= bus_wdata[1];
            end
            if (done_evt_i)
                istat_q <= 1'b1;
            else if (wr && sel == SEL_ISTAT && bus_wdata[0])
                istat_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                SEL_REV:   bus_rdata = REV_VALUE;
                SEL_CFG:   bus_rdata[0] = cfg_q;
                SEL_ISTAT: bus_rdata[0] = istat_q;
                SEL_IEN:   bus_rdata[0] = ien_q;
                SEL_GAIN:  bus_rdata = gain_q;
                SEL_CTRL:  bus_rdata[2:0] = {done_i, ctrl_q.load_en, ctrl_q.st_on};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign coef_wr_o = wr && sel == SEL_COEF;
    assign ctrl_o    = ctrl_q;
    assign gain_o    = gain_q;
    assign idle_o    = cfg_q;
endmodule

// File: rtl/st_coef_loader.sv
module st_coef_loader #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic          coef_wr,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_idx_o,
    output logic          done_o,
    output logic          done_evt_o,
    output logic [PW-1:0] ptr_o
);
    logic [PW-1:0] ptr_q;
    logic          done_q;

    assign wr_en_o    = load_en && coef_wr && !done_q;
    assign wr_idx_o   = ptr_q[AW-1:0];
    assign done_evt_o = wr_en_o && ptr_q == PW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || !load_en) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else if (wr_en_o) begin
            ptr_q <= ptr_q + 1'b1;
            if (done_evt_o) done_q <= 1'b1;
        end
    end

    assign done_o = done_q;
    assign ptr_o  = ptr_q;
endmodule

// File: rtl/st_coef_table.sv
module st_coef_table #(
    parameter int DEPTH = 128,
    parameter int CW    = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [CW-1:0] rdata
);
    logic [CW-1:0] mem [DEPTH];
    logic [CW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            if (we) mem[widx] <= wdata;
            rd_q <= mem[ridx];
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/st_coef_ctrl.sv
module st_coef_ctrl
    import st_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [AW-1:0]     tap_idx,
    output logic [COEF_W-1:0] tap_val,
    output logic              st_on,
    output logic              idle_req,
    output logic [COEF_W-1:0] gain_ch0,
    output logic [COEF_W-1:0] gain_ch1
);
    ctrl_t         ctrl;
    gain_t         gain;
    logic          coef_wr, load_en, done, done_evt, tbl_we;
    logic [AW-1:0] widx;
    logic [PW-1:0] ptr;

    st_regbank u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .done_i(done), .done_evt_i(done_evt),
        .bus_rdata(bus_rdata), .coef_wr_o(coef_wr),
        .ctrl_o(ctrl), .gain_o(gain), .idle_o(idle_req)
    );

    assign load_en = ctrl.load_en;

    st_coef_loader #(.DEPTH(DEPTH)) u_loader (
        .clk(clk), .rst(rst), .load_en(load_en), .coef_wr(coef_wr),
        .wr_en_o(tbl_we), .wr_idx_o(widx), .done_o(done),
        .done_evt_o(done_evt), .ptr_o(ptr)
    );

    st_coef_table #(.DEPTH(DEPTH), .CW(COEF_W)) u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .widx(widx),
        .wdata(bus_wdata[COEF_W-1:0]), .ridx(tap_idx), .rdata(tap_val)
    );

    assign st_on    = ctrl.st_on;
    assign gain_ch0 = gain.ch0;
    assign gain_ch1 = gain.ch1;
endmodule

// File: rtl/st_coef_ctrl_chk.sv
module st_coef_ctrl_chk
    import st_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int PW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic [COEF_W-1:0] gain_ch0,
    input logic [COEF_W-1:0] gain_ch1,
    input logic              load_en,
    input logic              done,
    input logic [PW-1:0]     ptr
);
    // R1
    rev_const_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we && bus_addr == OFS_REV) |-> bus_rdata == REV_VALUE);

    // R3
    gain_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == OFS_GAIN) |=>
        (gain_ch0 == $past(bus_wdata[15:0]) && gain_ch1 == $past(bus_wdata[31:16])));

    // R7
    load_off_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> (!done && ptr == '0));

    // R6
    done_full_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ptr == PW'(DEPTH));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(ptr) == PW'(DEPTH - 1));

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == OFS_COEF && !load_en) |=> ptr == '0);
endmodule

bind st_coef_ctrl st_coef_ctrl_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
    .load_en(load_en), .done(done), .ptr(ptr)
);

// File: tb/tb_st_coef_ctrl.sv
module tb_st_coef_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  tap_idx = '0;
    logic [15:0] tap_val;
    logic        st_on, idle_req;
    logic [15:0] gain_ch0, gain_ch1;

    int tests = 0, fails = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    st_coef_ctrl dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tap_idx(tap_idx), .tap_val(tap_val), .st_on(st_on),
        .idle_req(idle_req), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] val;
    } vec_t;

    // R1 rev, R2 cfg, R3 gain, R4 ctrl, R9 irq enable, R5 data readback
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 1'b1, 8'h00, 32'hFFFF_FFFF},
        '{4'd1, 1'b0, 8'h00, 32'h0001_0200},
        '{4'd2, 1'b1, 8'h10, 32'hFFFF_FFFF},
        '{4'd2, 1'b0, 8'h10, 32'h0000_0001},
        '{4'd3, 1'b1, 8'h24, 32'h8000_7FFF},
        '{4'd3, 1'b0, 8'h24, 32'h8000_7FFF},
        '{4'd4, 1'b1, 8'h2C, 32'h0000_0005},
        '{4'd4, 1'b0, 8'h2C, 32'h0000_0001},
        '{4'd9, 1'b1, 8'h1C, 32'hFFFF_FFFF},
        '{4'd9, 1'b0, 8'h1C, 32'h0000_0001},
        '{4'd5, 1'b0, 8'h28, 32'h0000_0000},
        '{4'd4, 1'b1, 8'h2C, 32'h0000_0000},
        '{4'd4, 1'b0, 8'h2C, 32'h0000_0000}
    };

    function automatic logic [15:0] cval(input int i);
        return 16'((i * 613 + 17) & 16'hFFFF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic tap(input int i, output logic [15:0] v);
        @(negedge clk);
        tap_idx = 7'(i);
        @(negedge clk);
        v = tap_val;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] tv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rdreg(8'h2C, rd); check("R10 ctrl", rd, 0);
        rdreg(8'h24, rd); check("R10 gain", rd, 0);
        tap(5, tv);       check("R10 tap", {16'h0, tv}, 0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].we) wr(VEC[k].addr, VEC[k].val);
            else begin
                rdreg(VEC[k].addr, rd);
                check($sformatf("R%0d vec %0d", VEC[k].req, k), rd, VEC[k].val);
            end
        end
        // R2 R3 R4 outputs
        check("R2 idle_req", {31'h0, idle_req}, 1);
        check("R3 gain_ch0", {16'h0, gain_ch0}, 32'h7FFF);
        check("R3 gain_ch1", {16'h0, gain_ch1}, 32'h8000);
        check("R4 st_on", {31'h0, st_on}, 0);

        // R5 full load with junk upper bits
        wr(8'h2C, 32'h2);
        for (int i = 0; i < 127; i++) wr(8'h28, {16'hA5A5, cval(i)});
        rdreg(8'h2C, rd); check("R6 not done at 127", rd, 32'h2);
        wr(8'h28, {16'h5A5A, cval(127)});
        rdreg(8'h2C, rd); check("R6 done at 128", rd, 32'h6);
        rdreg(8'h18, rd); check("R9 status set", rd, 1);
        wr(8'h28, 32'h0000_1234);   // R6 extra write ignored
        rdreg(8'h2C, rd); check("R6 done held", rd, 32'h6);
        for (int i = 0; i < 128; i++) begin
            tap(i, tv); check("R5 R8 table", {16'h0, tv}, {16'h0, cval(i)});
        end

        // R9 write-1-to-clear
        wr(8'h18, 32'h0);
        rdreg(8'h18, rd); check("R9 zero write keeps", rd, 1);
        wr(8'h18, 32'h1);
        rdreg(8'h18, rd); check("R9 cleared", rd, 0);

        // R7 restart mid-load
        wr(8'h2C, 32'h0);
        rdreg(8'h2C, rd); check("R7 done cleared", rd, 0);
        wr(8'h2C, 32'h2);
        for (int i = 0; i < 3; i++) wr(8'h28, {16'h0, ~cval(i)});
        wr(8'h2C, 32'h0);
        wr(8'h28, 32'h0000_BEEF);   // ignored, load enable low
        tap(0, tv); check("R7 ignored write", {16'h0, tv}, {16'h0, ~cval(0)});
        wr(8'h2C, 32'h2);
        wr(8'h28, 32'h0000_0C0C);
        tap(0, tv); check("R7 restart index 0", {16'h0, tv}, 32'h0C0C);
        tap(1, tv); check("R7 entry 1 kept", {16'h0, tv}, {16'h0, ~cval(1)});
        tap(3, tv); check("R7 entry 3 kept", {16'h0, tv}, {16'h0, cval(3)});
        rdreg(8'h18, rd); check("R9 no early status", rd, 0);

        // R10 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rdreg(8'h2C, rd); check("R10 ctrl after reset", rd, 0);
        rdreg(8'h10, rd); check("R10 cfg after reset", rd, 0);
        tap(3, tv); check("R10 table cleared", {16'h0, tv}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule